// File: doc/BRIEF.md
# Dual-Mode Buffered PWM Timer

This block is a free-running up-counter that drives a small set of pulse-width-modulated outputs. A prescaler divides the clock by a power of two and sets the counter's tick rate. The counter runs from zero up to a top value inclusive and then wraps. A control bit selects the width of the count. In narrow (8-bit) mode a dedicated period register supplies the top, and every channel compares the count against its own compare register. In wide (16-bit) mode compare register 0 serves as the top. Channel 0 then has no waveform of its own, and channel 1 carries the only PWM output.

Software writes registers through a simple address/data strobe. Each accepted write passes through a synchronisation delay of a fixed number of cycles, and a busy flag stays raised during that delay. A write that arrives while busy is high is dropped. Period and compare writes land in buffer registers. The counter copies them into the active set only at the wrap, so a duty or period change never produces a truncated or doubled pulse. Each channel has an output-invert bit, and the invert mask can be changed only while the counter is stopped. A self-clearing soft-reset bit returns every register to its default value.

Register map (address: content). 0 is control: bit 0 enable, bit 1 wide mode, bit 2 soft reset, bits 6:4 prescale select. 1 is the invert mask, bit n for channel n. 2 is the narrow period. 3 is compare 0. 4 is compare 1.

Top module: `pwm_timer`

## Requirements
- R1: After the reset input and after a soft reset, busy is 0, all outputs are 0, the counter is stopped, and both the period register and compare register 0 hold 1. Compare register 1 and the invert mask hold 0.
- R2: In narrow mode the top is the period register. Every channel n is active while count < compare n. One period lasts top+1 prescaled ticks.
- R3: In wide mode (control bit 1 = 1) compare register 0 is the top, and channel 1 is active while count < compare 1. Channel 0 stays at its inactive level, which equals its invert bit. The mode bit is taken only while the counter is stopped.
- R4: A compare value of 0 keeps the channel inactive for the whole period. A compare value above the top keeps it active for the whole period.
- R5: Period and compare writes go into buffers. The active values change only when the counter wraps from top to 0.
- R6: Setting invert bit n (address 1) inverts the polarity of channel n.
- R7: A write to the invert mask while the counter is enabled is ignored.
- R8: An accepted write raises busy on the next cycle. Busy stays high for SYNC_CYCLES cycles (default 2), and the write takes effect on the edge where busy falls. A write presented while busy is high is dropped.
- R9: Writing control bit 2 = 1 restores every register to its R1 default.
- R10: Prescale select s (control bits 6:4) makes the counter advance once every 2^s clock cycles.
- R11: In narrow mode only bits 7:0 of a period or compare write are stored, and the upper byte is ignored.
- R12: Clearing the enable bit freezes the count, and each output then sits at its inactive level (its invert bit). On re-enable the count resumes from the frozen value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| busy | output | 1 | Synchronisation in progress; new writes are dropped |
| pwm_out | output | 2 | PWM outputs, one per channel |

## Verification
The bench counts active samples over a window of whole periods, so duty and period checks do not depend on the counter's phase. This exposes a wrong top, an off-by-one period, or a wrong prescale ratio as a wrong high count. The 0% and 100% compare limits are checked, and so is the upper-byte truncation in narrow mode. A design that kept the upper byte would produce a long period that stays always high. A compare value changed mid-period must not shift the current pulse, and a design that commits immediately would raise the output before the wrap. Three more cases are covered: a polarity write while the counter runs, a second write presented while busy is high, and a stop followed by a restart. A design that lets either write through shows the wrong idle level. A design that clears the count on disable shows an immediate high pulse on restart.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int unsigned PWM_DW = 16;
  localparam int unsigned PWM_NW = 8;
  localparam int unsigned PWM_AW = 3;

  typedef logic [PWM_DW-1:0] word_t;

  typedef enum logic [PWM_AW-1:0] {
    ADR_CTRL = 3'd0,
    ADR_INV  = 3'd1,
    ADR_PER  = 3'd2,
    ADR_CMP0 = 3'd3,
    ADR_CMP1 = 3'd4
  } reg_addr_e;

  localparam int unsigned CB_EN      = 0;
  localparam int unsigned CB_WIDE    = 1;
  localparam int unsigned CB_SRST    = 2;
  localparam int unsigned CB_PSC_LSB = 4;

  localparam word_t TOP_DEFAULT = word_t'(1);

  typedef struct packed {
    logic              valid;
    logic [PWM_AW-1:0] addr;
    word_t             data;
  } apply_t;

  // Narrow mode keeps only the low byte of a write.
  function automatic word_t trim_lane(input logic wide, input word_t d);
    return wide ? d : {{(PWM_DW-PWM_NW){1'b0}}, d[PWM_NW-1:0]};
  endfunction

  function automatic word_t select_top(input logic wide, input word_t per, input word_t cmp0);
    return wide ? cmp0 : per;
  endfunction

  function automatic logic duty_active(input word_t cnt, input word_t cmp);
    return cnt < cmp;
  endfunction

  function automatic word_t cmp_default(input int idx);
    return (idx == 0) ? TOP_DEFAULT : '0;
  endfunction
endpackage

// File: rtl/pwm_sync.sv
module pwm_sync
  import pwm_pkg::*;
#(
  parameter int unsigned SYNC_CYCLES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PWM_AW-1:0] wr_addr,
  input  word_t             wr_data,
  output logic              busy,
  output apply_t            apply
);
  localparam int unsigned CW = $clog2(SYNC_CYCLES + 1);

  logic [CW-1:0]     cnt;
  logic [PWM_AW-1:0] st_addr;
  word_t             st_data;
  logic              accept;

  assign accept = wr_en && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      st_addr <= '0;
      st_data <= '0;
    end else if (accept) begin
      cnt     <= CW'(SYNC_CYCLES);
      st_addr <= wr_addr;
      st_data <= wr_data;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign busy        = (cnt != '0);
  assign apply.valid = (cnt == CW'(1));
  assign apply.addr  = st_addr;
  assign apply.data  = st_data;

  AST_BUSY_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy); // R8
  AST_APPLY_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    apply.valid |=> !apply.valid); // R8
  AST_DROP_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !apply.valid) |=> $stable(st_data)); // R8
endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int unsigned SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int unsigned DIV_W = (1 << SEL_W) - 1;

  logic [DIV_W-1:0] pcnt;
  logic [DIV_W-1:0] limit;

  // limit = 2^sel - 1, built bit by bit
  always_comb begin
    limit = '0;
    for (int b = 0; b < DIV_W; b++) begin
      if (b < int'(sel)) limit[b] = 1'b1;
    end
  end

  assign tick = run && (pcnt >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt <= '0;
    end else if (clr) begin
      pcnt <= '0;
    end else if (run) begin
      pcnt <= tick ? '0 : pcnt + 1'b1;
    end
  end

  AST_IDLE_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr) |=> $stable(pcnt)); // R12
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter
  import pwm_pkg::*;
#(
  parameter int unsigned NUM_CH = 2
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   clr,
  input  logic   restart,
  input  logic   tick,
  input  logic   wide,
  input  apply_t ap,
  output word_t  count,
  output word_t  top,
  output logic   wrap,
  output word_t  cmp_act [NUM_CH]
);
  word_t per_buf, per_act;
  word_t cmp_buf [NUM_CH];

  assign top  = select_top(wide, per_act, cmp_act[0]);
  assign wrap = tick && (count >= top);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count   <= '0;
      per_buf <= TOP_DEFAULT;
      per_act <= TOP_DEFAULT;
      for (int i = 0; i < NUM_CH; i++) begin
        cmp_buf[i] <= cmp_default(i);
        cmp_act[i] <= cmp_default(i);
      end
    end else if (clr) begin
      count   <= '0;
      per_buf <= TOP_DEFAULT;
      per_act <= TOP_DEFAULT;
      for (int i = 0; i < NUM_CH; i++) begin
        cmp_buf[i] <= cmp_default(i);
        cmp_act[i] <= cmp_default(i);
      end
    end else begin
      if (restart) begin
        count <= '0;
      end else if (tick) begin
        count <= wrap ? '0 : count + 1'b1;
      end
      if (ap.valid && (ap.addr == ADR_PER)) per_buf <= trim_lane(wide, ap.data);
      if (wrap) per_act <= per_buf;
      for (int i = 0; i < NUM_CH; i++) begin
        if (ap.valid && (ap.addr == PWM_AW'(int'(ADR_CMP0) + i)))
          cmp_buf[i] <= trim_lane(wide, ap.data);
        if (wrap) cmp_act[i] <= cmp_buf[i];
      end
    end
  end

  AST_COUNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    count <= top); // R2
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !clr && !restart) |=> $stable(count)); // R12
  AST_PER_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!wrap && !clr) |=> $stable(per_act)); // R5

  for (genvar g = 0; g < NUM_CH; g++) begin : g_commit
    AST_COMMIT_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (!wrap && !clr) |=> $stable(cmp_act[g])); // R5
  end
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
  import pwm_pkg::*;
#(
  parameter int unsigned CH_IDX = 0
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  en,
  input  logic  wide,
  input  logic  inv,
  input  word_t count,
  input  word_t cmp,
  output logic  out
);
  logic owns_top;
  logic raw;

  assign owns_top = wide && (CH_IDX == 0);
  assign raw      = en && !owns_top && duty_active(count, cmp);
  assign out      = raw ^ inv;

  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (out == inv)); // R12
  AST_ZERO_DUTY: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp == '0) |-> (out == inv)); // R4
  if (CH_IDX == 0) begin : g_top_owner
    AST_WIDE_CH0_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      wide |-> (out == inv)); // R3
  end
endmodule

// File: rtl/pwm_timer.sv
module pwm_timer
  import pwm_pkg::*;
#(
  parameter int unsigned SYNC_CYCLES = 2,
  parameter int unsigned PSC_SEL_W   = 3,
  parameter int unsigned NUM_CH      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PWM_AW-1:0] wr_addr,
  input  logic [PWM_DW-1:0] wr_data,
  output logic              busy,
  output logic [NUM_CH-1:0] pwm_out
);
  apply_t               ap;
  logic                 en_q, wide_q;
  logic [PSC_SEL_W-1:0] psc_q;
  logic [NUM_CH-1:0]    inv_q;
  logic                 ctrl_hit, soft_rst, mode_restart, inv_hit;
  logic                 tick, wrap;
  word_t                count, top;
  word_t                cmp_act [NUM_CH];

  pwm_sync #(.SYNC_CYCLES(SYNC_CYCLES)) i_sync (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .busy(busy), .apply(ap)
  );

  assign ctrl_hit     = ap.valid && (ap.addr == ADR_CTRL);
  assign soft_rst     = ctrl_hit && ap.data[CB_SRST];
  assign inv_hit      = ap.valid && (ap.addr == ADR_INV);
  assign mode_restart = ctrl_hit && !soft_rst && !en_q && (ap.data[CB_WIDE] != wide_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      wide_q <= 1'b0;
      psc_q  <= '0;
      inv_q  <= '0;
    end else if (soft_rst) begin
      en_q   <= 1'b0;
      wide_q <= 1'b0;
      psc_q  <= '0;
      inv_q  <= '0;
    end else begin
      if (ctrl_hit) begin
        en_q  <= ap.data[CB_EN];
        psc_q <= ap.data[CB_PSC_LSB +: PSC_SEL_W];
        if (!en_q) wide_q <= ap.data[CB_WIDE];
      end
      if (inv_hit && !en_q) inv_q <= ap.data[NUM_CH-1:0];
    end
  end

  pwm_prescaler #(.SEL_W(PSC_SEL_W)) i_psc (
    .clk(clk), .rst_n(rst_n), .clr(soft_rst), .run(en_q), .sel(psc_q), .tick(tick)
  );

  pwm_counter #(.NUM_CH(NUM_CH)) i_cnt (
    .clk(clk), .rst_n(rst_n), .clr(soft_rst), .restart(mode_restart), .tick(tick),
    .wide(wide_q), .ap(ap), .count(count), .top(top), .wrap(wrap), .cmp_act(cmp_act)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    pwm_channel #(.CH_IDX(c)) i_ch (
      .clk(clk), .rst_n(rst_n), .en(en_q), .wide(wide_q), .inv(inv_q[c]),
      .count(count), .cmp(cmp_act[c]), .out(pwm_out[c])
    );
  end

  AST_INV_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !soft_rst) |=> $stable(inv_q)); // R7
  AST_SRST_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (!en_q && (inv_q == '0) && (pwm_out == '0) && (top == TOP_DEFAULT))); // R9
  AST_MODE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !soft_rst) |=> $stable(wide_q)); // R3
  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !soft_rst) |=> (count == '0)); // R2
endmodule

// File: tb/test_pwm_timer.sv
module test_pwm_timer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        busy;
  logic [1:0]  pwm_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_timer i_pwm_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .busy(busy), .pwm_out(pwm_out)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    for (int i = 0; i < 50 && busy; i++) @(negedge clk);
  endtask

  task automatic soft_reset();
    wr(3'd0, 16'h0004);
  endtask

  task automatic count_high(input int ch, input int n, output int hi);
    hi = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm_out[ch]) hi++;
    end
  endtask

  task automatic wait_level(input int ch, input logic lvl);
    for (int i = 0; i < 2000 && (pwm_out[ch] != lvl); i++) @(negedge clk);
  endtask

  task automatic settle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 busy after reset", int'(busy), 0);
    check("R1 outputs after reset", int'(pwm_out), 0);
  endtask

  task automatic t_narrow_basic();
    int hi;
    soft_reset();
    wr(3'd2, 16'd9); wr(3'd3, 16'd3); wr(3'd4, 16'd7);
    wr(3'd0, 16'h0001);
    settle(40);
    count_high(0, 20, hi); check("R2 narrow ch0 duty", hi, 6);
    count_high(1, 20, hi); check("R2 narrow ch1 duty", hi, 14);
    wr(3'd1, 16'h0003);
    count_high(0, 20, hi); check("R7 invert write while enabled ignored", hi, 6);
  endtask

  task automatic t_duty_limits();
    int hi;
    soft_reset();
    wr(3'd2, 16'd9); wr(3'd3, 16'd0); wr(3'd4, 16'd10);
    wr(3'd0, 16'h0001);
    settle(40);
    count_high(0, 20, hi); check("R4 compare zero never active", hi, 0);
    count_high(1, 20, hi); check("R4 compare above top always active", hi, 20);
  endtask

  task automatic t_wide();
    int hi;
    soft_reset();
    wr(3'd0, 16'h0002);
    wr(3'd3, 16'd299); wr(3'd4, 16'd100);
    wr(3'd0, 16'h0003);
    settle(40);
    count_high(1, 600, hi); check("R3 wide ch1 duty", hi, 200);
    count_high(0, 600, hi); check("R3 wide ch0 held inactive", hi, 0);
  endtask

  task automatic t_prescale();
    int hi;
    soft_reset();
    wr(3'd0, 16'h0020);
    wr(3'd2, 16'd4); wr(3'd4, 16'd2);
    wr(3'd0, 16'h0021);
    settle(40);
    count_high(1, 40, hi); check("R10 divide by 4 duty", hi, 16);
  endtask

  task automatic t_upper_byte();
    int hi;
    soft_reset();
    wr(3'd2, 16'h0109); wr(3'd4, 16'h0203);
    wr(3'd0, 16'h0001);
    settle(40);
    count_high(1, 20, hi); check("R11 upper byte ignored", hi, 6);
  endtask

  task automatic t_invert();
    int hi;
    soft_reset();
    wr(3'd1, 16'h0002);
    @(negedge clk);
    check("R6 idle level with ch1 inverted", int'(pwm_out), 2);
    wr(3'd2, 16'd9); wr(3'd4, 16'd3);
    wr(3'd0, 16'h0001);
    settle(40);
    count_high(1, 20, hi); check("R6 inverted ch1 duty", hi, 14);
  endtask

  task automatic t_busy();
    soft_reset();
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'd1; wr_data = 16'h0001;
    @(negedge clk);
    check("R8 busy after accepted write", int'(busy), 1);
    wr_data = 16'h0000;
    @(negedge clk);
    wr_en = 1'b0;
    check("R8 busy still high", int'(busy), 1);
    @(negedge clk);
    check("R8 busy falls after sync delay", int'(busy), 0);
    check("R8 write while busy dropped", int'(pwm_out), 1);
  endtask

  task automatic t_commit();
    int hi;
    soft_reset();
    wr(3'd2, 16'd199); wr(3'd4, 16'd50);
    wr(3'd0, 16'h0001);
    wait_level(1, 1'b1);
    wait_level(1, 1'b0);
    wr(3'd4, 16'd150);
    count_high(1, 100, hi); check("R5 no change before wrap", hi, 0);
    count_high(1, 400, hi); check("R5 new compare after wrap", hi, 300);
  endtask

  task automatic t_freeze();
    int hi;
    soft_reset();
    wr(3'd2, 16'd19); wr(3'd4, 16'd5);
    wr(3'd0, 16'h0001);
    wait_level(1, 1'b1);
    wait_level(1, 1'b0);
    wr(3'd0, 16'h0000);
    count_high(1, 30, hi); check("R12 inactive while disabled", hi, 0);
    wr(3'd0, 16'h0001);
    check("R12 count resumes from frozen value", int'(pwm_out[1]), 0);
    count_high(1, 40, hi); check("R12 running again after resume", hi, 10);
  endtask

  task automatic t_soft_reset();
    int hi;
    soft_reset();
    wr(3'd1, 16'h0003);
    @(negedge clk);
    check("R9 inverted idle before soft reset", int'(pwm_out), 3);
    soft_reset();
    check("R9 outputs after soft reset", int'(pwm_out), 0);
    check("R9 busy after soft reset", int'(busy), 0);
    wr(3'd4, 16'd1);
    wr(3'd0, 16'h0001);
    settle(40);
    count_high(1, 20, hi); check("R1 default top of 1", hi, 10);
  endtask

  initial begin
    rst_n = 1'b0;
    settle(3);
    rst_n = 1'b1;
    t_reset();
    t_narrow_basic();
    t_duty_limits();
    t_wide();
    t_prescale();
    t_upper_byte();
    t_invert();
    t_busy();
    t_commit();
    t_freeze();
    t_soft_reset();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule